// File: doc/BRIEF.md
# CPU Address Decoder with Mirrored Work RAM

This block sits on the address bus of an 8-bit CPU with a 16-bit address space. It decides which target each access belongs to and presents a target-select code. For the two register windows it also presents a local offset. It holds the 2 KiB work RAM and an optional non-volatile RAM itself. It also holds a computed program ROM image aligned to the top of the upper half of the address space. It returns read data from all of these and from the external register sources.

Three register-window functions sit inside the block:

- A write to the sprite-transfer offset raises a one-cycle start pulse and latches the source page.
- A write to the first controller offset latches the strobe bit.
- Reads at the two controller offsets return the two port values.

Addresses that map to nothing read as zero and drop writes. A power-cycle input zeroes every RAM byte and leaves the ROM unchanged.

Top module: `cpu_addr_decoder`

## Requirements
- R1: Work RAM occupies 0x0000-0x07FF with target code 1. A write with `we` high takes effect at the clock edge, and a read returns the stored byte combinationally.
- R2: Addresses 0x0800-0x1FFF select target 1 and use addr[10:0] as the RAM index, so they alias the same bytes as 0x0000-0x07FF.
- R3: Addresses 0x2000-0x2007 select target 2 with `reg_off` = addr - 0x2000. A write raises `vid_we` in that cycle, a read returns `vid_rdata`, and 0x2008 is unmapped.
- R4: Addresses 0x4000-0x4017 select target 3 with `reg_off` = addr - 0x4000. A write raises `aud_we` except at offsets 0x14 and 0x16. A read returns `aud_rdata` except at offsets 0x16 and 0x17.
- R5: A write at 0x4014 sets `dma_start` high for exactly the next cycle and sets `dma_page` to the written byte shifted left by 8 bits; `dma_page` then holds.
- R6: A write at 0x4016 sets `pad_strobe` to wdata[0] from the next cycle. A read at 0x4016 returns `pad1_rdata` and a read at 0x4017 returns `pad2_rdata`.
- R7: With NV_BYTES nonzero (default 1024), 0x6000 up to 0x6000+NV_BYTES-1 selects target 4 as read/write RAM; the next address is unmapped.
- R8: Program ROM (default 16384 bytes) selects target 5 from 0x10000-ROM_BYTES to 0xFFFF. The byte at index i (address minus ROM base, zero-extended to 16 bits) is i[7:0] ^ i[15:8] ^ 0xA5.
- R9: A write to ROM changes no ROM byte and raises neither `vid_we` nor `aud_we`.
- R10: Unmapped addresses select target 0, read 0x00, raise no strobe and change no RAM byte.
- R11: A cycle with `pwr_clr` high zeroes every byte of work RAM and non-volatile RAM; ROM contents stay as in R8.
- R12: At most one target is hit for any address, and `reg_off` is zero outside targets 2 and 3.
- R13: While `rst_n` is low, and after it, `dma_start`, `dma_page` and `pad_strobe` are zero until written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_clr | input | 1 | Zero all RAM at the next edge |
| addr | input | 16 | CPU address |
| we | input | 1 | Write enable for the current access |
| wdata | input | 8 | Write data |
| vid_rdata | input | 8 | Read data from the video register window |
| aud_rdata | input | 8 | Read data from the audio/IO register window |
| pad1_rdata | input | 8 | Controller port 1 read value |
| pad2_rdata | input | 8 | Controller port 2 read value |
| rdata | output | 8 | Read data for the current address |
| tgt_sel | output | 3 | Target code: 0 none, 1 work RAM, 2 video, 3 audio/IO, 4 NV RAM, 5 ROM |
| reg_off | output | 5 | Offset within the video or audio/IO window |
| vid_we | output | 1 | Write strobe to the video registers |
| aud_we | output | 1 | Write strobe to the audio/IO registers |
| dma_start | output | 1 | One-cycle sprite-transfer start pulse |
| dma_page | output | 16 | Sprite-transfer source address |
| pad_strobe | output | 1 | Controller strobe level |

## Verification
The assertions assume the following about the inputs:

- `addr`, `we` and `wdata` are stable and defined around each rising edge.
- `pwr_clr` is not used to carry a write that is expected to survive, because the clear wins over a write in the same cycle.
- `rst_n` is low from time zero until the RAM has been cleared once.

The stimulus respects these assumptions:

- It changes inputs only on falling edges.
- It holds `we` low whenever `pwr_clr` is high.
- It clears the RAM during reset, so every read has a known expected value.

// File: rtl/cpu_dec_pkg.sv
// Package: shared target codes and the computed ROM content rule.
// Assumes: target codes are a fixed 3-bit encoding seen at the top ports.
package cpu_dec_pkg;

    typedef enum logic [2:0] {
        TGT_NONE  = 3'd0,
        TGT_WRAM  = 3'd1,
        TGT_VREG  = 3'd2,
        TGT_AREG  = 3'd3,
        TGT_NVRAM = 3'd4,
        TGT_ROM   = 3'd5
    } tgt_e;

    localparam int OFF_W = 5;

    // ROM content: byte at zero-extended index i
    function automatic logic [7:0] rom_byte(input logic [15:0] i);
        return i[7:0] ^ i[15:8] ^ 8'hA5;
    endfunction

endpackage

// File: rtl/cpu_dec_region.sv
// Region decoder: compares the address against every window and encodes
// one target, a window offset and per-store indices.
// Assumes: parameter ranges do not overlap; priority chain guards anyway.
module cpu_dec_region
    import cpu_dec_pkg::*;
#(
    parameter int WRAM_BYTES = 2048,
    parameter int WRAM_SPAN  = 'h2000,
    parameter int VREG_BASE  = 'h2000,
    parameter int VREG_COUNT = 8,
    parameter int AREG_BASE  = 'h4000,
    parameter int AREG_COUNT = 'h18,
    parameter int NV_BASE    = 'h6000,
    parameter int NV_BYTES   = 1024,
    parameter int ROM_BYTES  = 16384,
    localparam int WRAM_AW   = $clog2(WRAM_BYTES),
    localparam int NV_AW     = (NV_BYTES > 1) ? $clog2(NV_BYTES) : 1,
    localparam int ROM_AW    = $clog2(ROM_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [15:0]        addr,
    output tgt_e               tgt,
    output logic [OFF_W-1:0]   off,
    output logic [WRAM_AW-1:0] wram_idx,
    output logic [NV_AW-1:0]   nv_idx,
    output logic [ROM_AW-1:0]  rom_idx
);

    localparam int ROM_BASE = 'h10000 - ROM_BYTES;

    logic [16:0] a17;
    logic        hit_wram, hit_vreg, hit_areg, hit_nv, hit_rom;
    logic [15:0] vsub, asub, nsub, rsub;

    // Range compares, each independent of the others
    always_comb begin
        a17      = {1'b0, addr};
        hit_wram = a17 < 17'(WRAM_SPAN);
        hit_vreg = (a17 >= 17'(VREG_BASE)) && (a17 < 17'(VREG_BASE + VREG_COUNT));
        hit_areg = (a17 >= 17'(AREG_BASE)) && (a17 < 17'(AREG_BASE + AREG_COUNT));
        hit_nv   = (NV_BYTES != 0) && (a17 >= 17'(NV_BASE))
                   && (a17 < 17'(NV_BASE + NV_BYTES));
        hit_rom  = a17 >= 17'(ROM_BASE);
    end

    // Window-relative differences
    always_comb begin
        vsub = addr - 16'(VREG_BASE);
        asub = addr - 16'(AREG_BASE);
        nsub = addr - 16'(NV_BASE);
        rsub = addr - 16'(ROM_BASE);
    end

    // Priority encode into one target and its offset
    always_comb begin
        tgt = TGT_NONE;
        off = '0;
        if (hit_wram) begin
            tgt = TGT_WRAM;
        end else if (hit_vreg) begin
            tgt = TGT_VREG;
            off = vsub[OFF_W-1:0];
        end else if (hit_areg) begin
            tgt = TGT_AREG;
            off = asub[OFF_W-1:0];
        end else if (hit_nv) begin
            tgt = TGT_NVRAM;
        end else if (hit_rom) begin
            tgt = TGT_ROM;
        end
    end

    // Store indices: mirroring of work RAM falls out of truncation
    always_comb begin
        wram_idx = addr[WRAM_AW-1:0];
        nv_idx   = nsub[NV_AW-1:0];
        rom_idx  = rsub[ROM_AW-1:0];
    end

    // R12: the raw compares never overlap
    p_one_target_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit_wram, hit_vreg, hit_areg, hit_nv, hit_rom}));

    // R12: offset only inside a register window
    p_off_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt != TGT_VREG && tgt != TGT_AREG) |-> off == '0);

endmodule

// File: rtl/cpu_dec_ram.sv
// Byte RAM: synchronous write, combinational read, one-cycle full clear.
// Assumes: clear has priority over a write in the same cycle.
module cpu_dec_ram #(
    parameter int DEPTH = 2048,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    // Store update: clear everything, else write one byte
    always_ff @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end

    // Combinational read port
    assign rdata = mem[idx];

    // R11: after a clear any location reads zero
    p_clear_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> rdata == 8'h00);

    // R1: a write is visible at the same index one cycle later
    p_write_visible_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clr) ##1 (idx == $past(idx)) |-> rdata == $past(wdata));

endmodule

// File: rtl/cpu_dec_io.sv
// Register-window side effects: write strobes to the two windows, the
// sprite-transfer start pulse and page, and the controller strobe latch.
// Assumes: tgt/off come from the region decoder for the same address.
module cpu_dec_io
    import cpu_dec_pkg::*;
#(
    parameter int DMA_OFF  = 'h14,
    parameter int PAD1_OFF = 'h16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  tgt_e             tgt,
    input  logic [OFF_W-1:0] off,
    input  logic [7:0]       wdata,
    output logic             vid_we,
    output logic             aud_we,
    output logic             dma_start,
    output logic [15:0]      dma_page,
    output logic             pad_strobe
);

    logic dma_wr, pad_wr;

    // Special-offset write detection
    always_comb begin
        dma_wr = we && (tgt == TGT_AREG) && (off == OFF_W'(DMA_OFF));
        pad_wr = we && (tgt == TGT_AREG) && (off == OFF_W'(PAD1_OFF));
    end

    // Window write strobes, special offsets routed elsewhere
    always_comb begin
        vid_we = we && (tgt == TGT_VREG);
        aud_we = we && (tgt == TGT_AREG) && !dma_wr && !pad_wr;
    end

    // Registered transfer start, page and strobe level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_start  <= 1'b0;
            dma_page   <= 16'h0000;
            pad_strobe <= 1'b0;
        end else begin
            dma_start <= dma_wr;
            if (dma_wr) dma_page <= {wdata, 8'h00};
            if (pad_wr) pad_strobe <= wdata[0];
        end
    end

    // R5: start pulse follows a transfer write
    p_dma_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dma_wr |=> dma_start);

    // R5: no pulse without a transfer write
    p_dma_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_wr |=> !dma_start);

    // R5: page is the written byte shifted up
    p_dma_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dma_wr |=> dma_page == {$past(wdata), 8'h00});

    // R6: strobe level follows bit 0 of the write
    p_pad_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pad_wr |=> pad_strobe == $past(wdata[0]));

    // R4: never both window strobes
    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(vid_we && aud_we));

endmodule

// File: rtl/cpu_addr_decoder.sv
// Top: CPU address decoder. Routes each access to work RAM, the video or
// audio/IO register windows, optional NV RAM or program ROM, and muxes
// the read data. Unmapped accesses read zero and write nothing.
// Assumes: inputs are stable around the rising edge of clk.
module cpu_addr_decoder
    import cpu_dec_pkg::*;
#(
    parameter int WRAM_BYTES = 2048,
    parameter int WRAM_SPAN  = 'h2000,
    parameter int VREG_BASE  = 'h2000,
    parameter int VREG_COUNT = 8,
    parameter int AREG_BASE  = 'h4000,
    parameter int AREG_COUNT = 'h18,
    parameter int NV_BASE    = 'h6000,
    parameter int NV_BYTES   = 1024,
    parameter int ROM_BYTES  = 16384,
    parameter int DMA_OFF    = 'h14,
    parameter int PAD1_OFF   = 'h16,
    parameter int PAD2_OFF   = 'h17
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pwr_clr,
    input  logic [15:0] addr,
    input  logic        we,
    input  logic [7:0]  wdata,
    input  logic [7:0]  vid_rdata,
    input  logic [7:0]  aud_rdata,
    input  logic [7:0]  pad1_rdata,
    input  logic [7:0]  pad2_rdata,
    output logic [7:0]  rdata,
    output logic [2:0]  tgt_sel,
    output logic [4:0]  reg_off,
    output logic        vid_we,
    output logic        aud_we,
    output logic        dma_start,
    output logic [15:0] dma_page,
    output logic        pad_strobe
);

    localparam int WRAM_AW = $clog2(WRAM_BYTES);
    localparam int NV_AW   = (NV_BYTES > 1) ? $clog2(NV_BYTES) : 1;
    localparam int ROM_AW  = $clog2(ROM_BYTES);

    tgt_e               tgt;
    logic [OFF_W-1:0]   off;
    logic [WRAM_AW-1:0] wram_idx;
    logic [NV_AW-1:0]   nv_idx;
    logic [ROM_AW-1:0]  rom_idx;
    logic [7:0]         wram_q, nv_q, rom_q;

    cpu_dec_region #(
        .WRAM_BYTES(WRAM_BYTES), .WRAM_SPAN(WRAM_SPAN),
        .VREG_BASE(VREG_BASE),   .VREG_COUNT(VREG_COUNT),
        .AREG_BASE(AREG_BASE),   .AREG_COUNT(AREG_COUNT),
        .NV_BASE(NV_BASE),       .NV_BYTES(NV_BYTES),
        .ROM_BYTES(ROM_BYTES)
    ) u_region (
        .clk(clk), .rst_n(rst_n), .addr(addr), .tgt(tgt), .off(off),
        .wram_idx(wram_idx), .nv_idx(nv_idx), .rom_idx(rom_idx)
    );

    cpu_dec_ram #(.DEPTH(WRAM_BYTES)) u_wram (
        .clk(clk), .rst_n(rst_n), .clr(pwr_clr),
        .we(we && tgt == TGT_WRAM), .idx(wram_idx),
        .wdata(wdata), .rdata(wram_q)
    );

    // Optional NV RAM, absent when its size is zero
    generate
        if (NV_BYTES > 0) begin : g_nv
            cpu_dec_ram #(.DEPTH(NV_BYTES)) u_nvram (
                .clk(clk), .rst_n(rst_n), .clr(pwr_clr),
                .we(we && tgt == TGT_NVRAM), .idx(nv_idx),
                .wdata(wdata), .rdata(nv_q)
            );
        end else begin : g_no_nv
            assign nv_q = 8'h00;
        end
    endgenerate

    // Computed ROM image, no write path
    assign rom_q = rom_byte(16'(rom_idx));

    cpu_dec_io #(.DMA_OFF(DMA_OFF), .PAD1_OFF(PAD1_OFF)) u_io (
        .clk(clk), .rst_n(rst_n), .we(we), .tgt(tgt), .off(off),
        .wdata(wdata), .vid_we(vid_we), .aud_we(aud_we),
        .dma_start(dma_start), .dma_page(dma_page), .pad_strobe(pad_strobe)
    );

    // Read-data mux by target
    always_comb begin
        unique case (tgt)
            TGT_WRAM:  rdata = wram_q;
            TGT_VREG:  rdata = vid_rdata;
            TGT_AREG: begin
                if (off == OFF_W'(PAD1_OFF))      rdata = pad1_rdata;
                else if (off == OFF_W'(PAD2_OFF)) rdata = pad2_rdata;
                else                              rdata = aud_rdata;
            end
            TGT_NVRAM: rdata = nv_q;
            TGT_ROM:   rdata = rom_q;
            default:   rdata = 8'h00;
        endcase
    end

    // Port outputs
    assign tgt_sel = tgt;
    assign reg_off = off;

    // R10: unmapped reads are zero and quiet
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_sel == 3'd0) |-> (rdata == 8'h00 && !vid_we && !aud_we));

    // R9: ROM accesses raise no window strobe
    p_rom_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_sel == 3'd5) |-> (!vid_we && !aud_we));

    // R13: outputs held clear during reset
    p_reset_clear_r13: assert property (@(posedge clk)
        !rst_n |=> (!dma_start && dma_page == 16'h0000 && !pad_strobe));

endmodule

// File: tb/cpu_addr_decoder_bench.sv
module cpu_addr_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_clr = 1'b1;
    logic [15:0] addr = 16'h0000;
    logic        we = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  vid_rdata = 8'h5C;
    logic [7:0]  aud_rdata = 8'h3A;
    logic [7:0]  pad1_rdata = 8'h41;
    logic [7:0]  pad2_rdata = 8'h82;
    logic [7:0]  rdata;
    logic [2:0]  tgt_sel;
    logic [4:0]  reg_off;
    logic        vid_we, aud_we, dma_start, pad_strobe;
    logic [15:0] dma_page;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cpu_addr_decoder u_cpu_addr_decoder (
        .clk(clk), .rst_n(rst_n), .pwr_clr(pwr_clr), .addr(addr), .we(we),
        .wdata(wdata), .vid_rdata(vid_rdata), .aud_rdata(aud_rdata),
        .pad1_rdata(pad1_rdata), .pad2_rdata(pad2_rdata), .rdata(rdata),
        .tgt_sel(tgt_sel), .reg_off(reg_off), .vid_we(vid_we), .aud_we(aud_we),
        .dma_start(dma_start), .dma_page(dma_page), .pad_strobe(pad_strobe)
    );

    // Vector: req[46:43] addr[42:27] we[26] wdata[25:18] tgt[17:15] off[14:10] rdata[9:2] {vid_we,aud_we}[1:0]
    localparam int NV = 28;
    localparam logic [46:0] VEC [NV] = '{
        {4'd1,  16'h0005, 1'b1, 8'h11, 3'd1, 5'h00, 8'h00, 2'b00}, // R1 write
        {4'd1,  16'h0005, 1'b0, 8'h00, 3'd1, 5'h00, 8'h11, 2'b00}, // R1 read
        {4'd2,  16'h0805, 1'b0, 8'h00, 3'd1, 5'h00, 8'h11, 2'b00}, // R2 mirror
        {4'd2,  16'h1805, 1'b0, 8'h00, 3'd1, 5'h00, 8'h11, 2'b00}, // R2 mirror
        {4'd2,  16'h1FFF, 1'b1, 8'h77, 3'd1, 5'h00, 8'h00, 2'b00}, // R2 write via mirror
        {4'd2,  16'h07FF, 1'b0, 8'h00, 3'd1, 5'h00, 8'h77, 2'b00}, // R2
        {4'd3,  16'h2003, 1'b0, 8'h00, 3'd2, 5'h03, 8'h5C, 2'b00}, // R3
        {4'd3,  16'h2007, 1'b1, 8'h3C, 3'd2, 5'h07, 8'h5C, 2'b10}, // R3 write strobe
        {4'd3,  16'h2008, 1'b0, 8'h00, 3'd0, 5'h00, 8'h00, 2'b00}, // R3 end of window
        {4'd4,  16'h4000, 1'b0, 8'h00, 3'd3, 5'h00, 8'h3A, 2'b00}, // R4
        {4'd4,  16'h4003, 1'b1, 8'h08, 3'd3, 5'h03, 8'h3A, 2'b01}, // R4 write strobe
        {4'd6,  16'h4016, 1'b0, 8'h00, 3'd3, 5'h16, 8'h41, 2'b00}, // R6 port 1
        {4'd6,  16'h4017, 1'b0, 8'h00, 3'd3, 5'h17, 8'h82, 2'b00}, // R6 port 2
        {4'd4,  16'h4014, 1'b0, 8'h00, 3'd3, 5'h14, 8'h3A, 2'b00}, // R4
        {4'd10, 16'h4018, 1'b0, 8'h00, 3'd0, 5'h00, 8'h00, 2'b00}, // R10
        {4'd7,  16'h6000, 1'b1, 8'h99, 3'd4, 5'h00, 8'h00, 2'b00}, // R7 write
        {4'd7,  16'h6000, 1'b0, 8'h00, 3'd4, 5'h00, 8'h99, 2'b00}, // R7 read
        {4'd7,  16'h63FF, 1'b0, 8'h00, 3'd4, 5'h00, 8'h00, 2'b00}, // R7 last byte
        {4'd7,  16'h6400, 1'b0, 8'h00, 3'd0, 5'h00, 8'h00, 2'b00}, // R7 past end
        {4'd8,  16'hC000, 1'b0, 8'h00, 3'd5, 5'h00, 8'hA5, 2'b00}, // R8
        {4'd8,  16'hFFFF, 1'b0, 8'h00, 3'd5, 5'h00, 8'h65, 2'b00}, // R8
        {4'd8,  16'hC123, 1'b0, 8'h00, 3'd5, 5'h00, 8'h87, 2'b00}, // R8
        {4'd8,  16'hBFFF, 1'b0, 8'h00, 3'd0, 5'h00, 8'h00, 2'b00}, // R8 below ROM
        {4'd9,  16'hC000, 1'b1, 8'h00, 3'd5, 5'h00, 8'hA5, 2'b00}, // R9 ROM write
        {4'd9,  16'hC000, 1'b0, 8'h00, 3'd5, 5'h00, 8'hA5, 2'b00}, // R9 unchanged
        {4'd10, 16'h8000, 1'b1, 8'h55, 3'd0, 5'h00, 8'h00, 2'b00}, // R10 dropped
        {4'd10, 16'h0000, 1'b0, 8'h00, 3'd1, 5'h00, 8'h00, 2'b00}, // R10 RAM untouched
        {4'd12, 16'h5000, 1'b0, 8'h00, 3'd0, 5'h00, 8'h00, 2'b00}  // R12 gap
    };

    task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] a, input logic w, input logic [7:0] d);
        @(negedge clk);
        addr = a; we = w; wdata = d;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1; pwr_clr = 1'b0;
        #1;
        // R13 reset state
        check("R13", "dma_start", 16'(dma_start), 16'h0);
        check("R13", "dma_page", dma_page, 16'h0000);
        check("R13", "pad_strobe", 16'(pad_strobe), 16'h0);

        for (int k = 0; k < NV; k++) begin
            logic [46:0] v;
            string rq;
            v = VEC[k];
            rq = $sformatf("R%0d v%0d", v[46:43], k);
            drive(v[42:27], v[26], v[25:18]);
            check(rq, "tgt_sel", 16'(tgt_sel), 16'(v[17:15]));
            check(rq, "reg_off", 16'(reg_off), 16'(v[14:10]));
            check(rq, "rdata", 16'(rdata), 16'(v[9:2]));
            check(rq, "strobes", 16'({vid_we, aud_we}), 16'(v[1:0]));
        end

        // R5 transfer start
        drive(16'h4014, 1'b1, 8'h02);
        check("R4", "aud_we at 0x14", 16'(aud_we), 16'h0);
        drive(16'h0000, 1'b0, 8'h00);
        check("R5", "dma_start pulse", 16'(dma_start), 16'h1);
        check("R5", "dma_page", dma_page, 16'h0200);
        drive(16'h0000, 1'b0, 8'h00);
        check("R5", "dma_start drops", 16'(dma_start), 16'h0);
        check("R5", "dma_page holds", dma_page, 16'h0200);

        // R6 controller strobe
        drive(16'h4016, 1'b1, 8'h01);
        check("R4", "aud_we at 0x16", 16'(aud_we), 16'h0);
        drive(16'h0000, 1'b0, 8'h00);
        check("R6", "pad_strobe set", 16'(pad_strobe), 16'h1);
        drive(16'h4016, 1'b1, 8'hFE);
        drive(16'h0000, 1'b0, 8'h00);
        check("R6", "pad_strobe clear", 16'(pad_strobe), 16'h0);

        // R11 power clear
        drive(16'h0005, 1'b0, 8'h00);
        check("R11", "ram before clear", 16'(rdata), 16'h0011);
        pwr_clr = 1'b1;
        drive(16'h0005, 1'b0, 8'h00);
        pwr_clr = 1'b0;
        check("R11", "work ram cleared", 16'(rdata), 16'h0000);
        drive(16'h07FF, 1'b0, 8'h00);
        check("R11", "work ram top cleared", 16'(rdata), 16'h0000);
        drive(16'h6000, 1'b0, 8'h00);
        check("R11", "nv ram cleared", 16'(rdata), 16'h0000);
        drive(16'hC123, 1'b0, 8'h00);
        check("R11", "rom intact", 16'(rdata), 16'h0087);

        finish_run();
    end

endmodule